// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether a load, a store or an instruction fetch may use a page whose entry was found in the hashed page table. Three independent permission sources each produce a read/write/execute set: a protection table indexed by the segment key and the entry's three-bit protection code, the entry's no-execute and guarded attributes, and a pair of per-key authority masks (one for data, one for instruction fetches). The three sets are ANDed. The access is granted when the required right is in the result.

When the access is denied, the block reports which source refused it. A fetch can report a no-execute/guard cause, a protection cause and an instruction-mask cause. A data access can report a protection cause, a data-mask cause and a store flag. When the access is granted, the block returns the referenced and changed bits to write back into the entry. It also states whether that write-back is needed. On a granted access that is not a store, it withholds write permission from the returned set, so that a later store comes back through the evaluator and can set the changed bit.

Results are registered. They appear one clock after the inputs. Raising the exceptions is left to the surrounding logic.

Top module: `page_perm_eval`

## Requirements
- R1: The segment key is `seg_kp` when `problem_state` is 1 and `seg_ks` otherwise.
- R2: The protection code is {`pte_lo[63]`, `pte_lo[1:0]`}. With key 0, codes 0, 1 and 2 give read/write/execute, codes 3 and 6 give read/execute, and all other codes give nothing.
- R3: With key 1, code 2 gives read/write/execute, codes 1 and 3 give read/execute, and all other codes (0, 4, 5, 6, 7) give nothing.
- R4: When no-execute `pte_lo[2]` or guarded `pte_lo[3]` is set, execute is removed and read and write are kept.
- R5: The page key is {`pte_lo[61:60]`, `pte_lo[11:9]`}. For key k, `dmask` bit 2*(31-k)+1 forbids stores and bit 2*(31-k) forbids loads. This applies when `key_mode` is not 0.
- R6: When `key_mode` is 2 or 3, `imask` bit 2*(31-k) forbids execute only. When `key_mode` is 1, `imask` has no effect.
- R7: When `key_mode` is 0, both masks have no effect and the mask source allows everything.
- R8: `acc_type` 0 is a load and needs read. 1 is a store and needs write. 2 is a fetch and needs execute. 3 is a fetch that is always denied. `grant` is 1 exactly when the needed right is in the AND of the three sources. On a grant, all fault bits are 0.
- R9: On a denied fetch, `flt_nxg` is set when no-execute/guard removed execute. `flt_prot` is set when the protection table lacks execute and `flt_nxg` is not set. `flt_imask` is set when the instruction mask removed execute.
- R10: On a denied load or store, `flt_prot` is set when the table lacks the needed right. `flt_dmask` is set when the data mask removed it. `flt_store` is set for stores. `flt_nxg` and `flt_imask` stay 0.
- R11: On a grant, `ref_bit` is 1. `chg_bit` is `pte_lo[7]`, or 1 on a store. `rc_update` is 1 when either bit differs from the entry (referenced is `pte_lo[8]`). On a non-store grant, `perm_w` is 0. On a denial, `ref_bit` and `chg_bit` echo the entry, `rc_update` is 0, and the perm outputs show the ANDed set.
- R12: All outputs are 0 while `rst_n` is low. Each result appears at the outputs one clock edge after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 denied fetch |
| problem_state | input | 1 | 1 for user-level access |
| seg_kp | input | 1 | Segment key used in problem state |
| seg_ks | input | 1 | Segment key used in privileged state |
| pte_lo | input | 64 | Second doubleword of the page table entry |
| dmask | input | 64 | Data authority mask, two bits per page key |
| imask | input | 64 | Instruction authority mask, two bits per page key |
| key_mode | input | 2 | 0 no key masks, 1 data mask only, 2/3 both masks |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| grant | output | 1 | Access allowed |
| flt_nxg | output | 1 | Fetch refused by no-execute/guard |
| flt_prot | output | 1 | Refused by the protection table |
| flt_imask | output | 1 | Fetch refused by instruction mask |
| flt_dmask | output | 1 | Data access refused by data mask |
| flt_store | output | 1 | Refused access was a store |
| rc_update | output | 1 | Referenced/changed write-back needed |
| ref_bit | output | 1 | New referenced bit |
| chg_bit | output | 1 | New changed bit |

## Verification
The evaluator holds no state except its output register, so a wrong decode shows up as a wrong field one clock after the offending input vector. There is no lasting corruption to wait for. The risky internals are the following:
- the key-to-mask bit position, which a reversed index turns into a refusal attributed to the wrong key;
- the two protection tables, where a swapped code shows up only for a particular key;
- cause priority on fetches.

Random vectors over all codes, keys and modes, together with directed cases for each table entry class and cause combination, expose each of these at the next sample.

// File: rtl/ppev_pkg.sv
// Package for the page access permission evaluator.
// Holds the shared widths, the entry bit positions the logic decodes,
// the access encoding and the permission-set type.
package ppev_pkg;
    localparam int PTE_W    = 64;
    localparam int KEY_W    = 5;
    localparam int NKEYS    = 1 << KEY_W;
    localparam int MASK_W   = 2 * NKEYS;

    // Positions of the entry fields that this block decodes
    localparam int POS_PP0  = 63;
    localparam int POS_PPLO = 0;
    localparam int POS_NX   = 2;
    localparam int POS_GRD  = 3;
    localparam int POS_CHG  = 7;
    localparam int POS_REF  = 8;
    localparam int POS_KLO  = 9;
    localparam int POS_KHI  = 60;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NOFET = 2'd3
    } acc_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    localparam perm_t PERM_RWX = '{r: 1'b1, w: 1'b1, x: 1'b1};
    localparam perm_t PERM_RX  = '{r: 1'b1, w: 1'b0, x: 1'b1};
    localparam perm_t PERM_RW  = '{r: 1'b1, w: 1'b1, x: 1'b0};
    localparam perm_t PERM_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};

    typedef struct packed {
        perm_t perm;
        logic  grant;
        logic  nxg;
        logic  prot;
        logic  imsk;
        logic  dmsk;
        logic  store;
        logic  rc_upd;
        logic  ref_b;
        logic  chg_b;
    } verdict_t;
endpackage

// File: rtl/ppev_pp_table.sv
// Protection-table source.
// Picks the segment key from the privilege level and maps the three-bit
// protection code to a permission set.
// Assumes the code is already assembled with the high-order bit on top.
module ppev_pp_table
    import ppev_pkg::*;
(
    input  logic       problem_state,
    input  logic       seg_kp,
    input  logic       seg_ks,
    input  logic [2:0] pp_code,
    output perm_t      pp_perm
);
    logic seg_key;

    // Key selection by privilege level
    always_comb begin
        seg_key = problem_state ? seg_kp : seg_ks;
    end

    // Code-to-permission table, one column per key value
    always_comb begin
        pp_perm = PERM_NONE;
        if (!seg_key) begin
            unique case (pp_code)
                3'd0, 3'd1, 3'd2: pp_perm = PERM_RWX;
                3'd3, 3'd6:       pp_perm = PERM_RX;
                default:          pp_perm = PERM_NONE;
            endcase
        end else begin
            unique case (pp_code)
                3'd2:       pp_perm = PERM_RWX;
                3'd1, 3'd3: pp_perm = PERM_RX;
                default:    pp_perm = PERM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ppev_mask_eval.sv
// Authority-mask source.
// Splits both mask registers into per-key two-bit fields. Key k owns
// bits 2*(NKEYS-1-k)+1 : 2*(NKEYS-1-k). Returns the permission set left
// after the data and instruction masks.
// Assumes key_mode 0 means masks are absent, and 1 means the data mask only.
module ppev_mask_eval
    import ppev_pkg::*;
#(
    parameter int KW = KEY_W,
    localparam int NK = 1 << KW,
    localparam int MW = 2 * NK
) (
    input  logic [KW-1:0] page_key,
    input  logic [MW-1:0] dmask,
    input  logic [MW-1:0] imask,
    input  logic [1:0]    key_mode,
    output perm_t         mask_perm
);
    logic [1:0] dfld [NK];
    logic [1:0] ifld [NK];

    // Per-key field extraction; key 0 sits in the top two bits
    for (genvar k = 0; k < NK; k++) begin : g_key
        assign dfld[k] = dmask[2*(NK-1-k) +: 2];
        assign ifld[k] = imask[2*(NK-1-k) +: 2];
    end

    logic [1:0] dsel;
    logic [1:0] isel;

    // Select the fields of the current page key
    always_comb begin
        dsel = dfld[page_key];
        isel = ifld[page_key];
    end

    // Remove rights according to the mode and the selected fields
    always_comb begin
        mask_perm = PERM_RWX;
        if (key_mode != 2'd0) begin
            if (dsel[1]) mask_perm.w = 1'b0;
            if (dsel[0]) mask_perm.r = 1'b0;
            if (key_mode[1] && isel[0]) mask_perm.x = 1'b0;
        end
    end
endmodule

// File: rtl/ppev_verdict.sv
// Decision and cause logic.
// ANDs the three permission sets, decides the grant, attributes a refusal
// to its sources and forms the referenced/changed write-back.
// Assumes the entry bits for referenced and changed arrive as inputs.
module ppev_verdict
    import ppev_pkg::*;
(
    input  logic [1:0] acc_type,
    input  perm_t      pp_perm,
    input  perm_t      nx_perm,
    input  perm_t      mask_perm,
    input  logic       old_ref,
    input  logic       old_chg,
    output verdict_t   vd
);
    perm_t need;
    perm_t all_perm;
    logic  is_fetch;
    logic  is_store;
    logic  denied;

    // Right needed by the access, and the combined set
    always_comb begin
        is_fetch = acc_type[1];
        is_store = (acc_type == ACC_STORE);
        unique case (acc_type)
            ACC_LOAD:  need = '{r: 1'b1, w: 1'b0, x: 1'b0};
            ACC_STORE: need = '{r: 1'b0, w: 1'b1, x: 1'b0};
            default:   need = '{r: 1'b0, w: 1'b0, x: 1'b1};
        endcase
        all_perm = pp_perm & nx_perm & mask_perm;
        denied   = ((need & ~all_perm) != 3'b000) || (acc_type == ACC_NOFET);
    end

    // Verdict, refusal causes and write-back bits
    always_comb begin
        vd        = '0;
        vd.perm   = all_perm;
        vd.grant  = !denied;
        vd.ref_b  = old_ref;
        vd.chg_b  = old_chg;
        if (denied) begin
            if (is_fetch) begin
                vd.nxg  = !nx_perm.x;
                vd.prot = nx_perm.x && !pp_perm.x;
                vd.imsk = !mask_perm.x;
            end else begin
                vd.prot  = ((need & ~pp_perm) != 3'b000);
                vd.dmsk  = ((need & ~mask_perm) != 3'b000);
                vd.store = is_store;
            end
        end else begin
            vd.ref_b  = 1'b1;
            vd.chg_b  = old_chg || is_store;
            vd.rc_upd = !old_ref || (is_store && !old_chg);
            if (!is_store) vd.perm.w = 1'b0;
        end
    end
endmodule

// File: rtl/page_perm_eval.sv
// Page access permission evaluator, top level.
// Assembles the protection code and the page key from the entry, runs the
// three permission sources and the verdict logic, and registers the result.
// Assumes a synchronous active-low reset that clears all outputs.
module page_perm_eval
    import ppev_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          acc_type,
    input  logic                problem_state,
    input  logic                seg_kp,
    input  logic                seg_ks,
    input  logic [PTE_W-1:0]    pte_lo,
    input  logic [MASK_W-1:0]   dmask,
    input  logic [MASK_W-1:0]   imask,
    input  logic [1:0]          key_mode,
    output logic                perm_r,
    output logic                perm_w,
    output logic                perm_x,
    output logic                grant,
    output logic                flt_nxg,
    output logic                flt_prot,
    output logic                flt_imask,
    output logic                flt_dmask,
    output logic                flt_store,
    output logic                rc_update,
    output logic                ref_bit,
    output logic                chg_bit
);
    logic [2:0]       pp_code;
    logic [KEY_W-1:0] page_key;
    perm_t            pp_perm;
    perm_t            nx_perm;
    perm_t            mask_perm;
    verdict_t         vd_d;
    verdict_t         vd_q;
    logic             vld_q;

    // Field assembly from the entry
    always_comb begin
        pp_code  = {pte_lo[POS_PP0], pte_lo[POS_PPLO +: 2]};
        page_key = {pte_lo[POS_KHI +: 2], pte_lo[POS_KLO +: 3]};
        nx_perm  = (pte_lo[POS_NX] || pte_lo[POS_GRD]) ? PERM_RW : PERM_RWX;
    end

    ppev_pp_table u_pp (
        .problem_state (problem_state),
        .seg_kp        (seg_kp),
        .seg_ks        (seg_ks),
        .pp_code       (pp_code),
        .pp_perm       (pp_perm)
    );

    ppev_mask_eval #(.KW(KEY_W)) u_mask (
        .page_key  (page_key),
        .dmask     (dmask),
        .imask     (imask),
        .key_mode  (key_mode),
        .mask_perm (mask_perm)
    );

    ppev_verdict u_vd (
        .acc_type  (acc_type),
        .pp_perm   (pp_perm),
        .nx_perm   (nx_perm),
        .mask_perm (mask_perm),
        .old_ref   (pte_lo[POS_REF]),
        .old_chg   (pte_lo[POS_CHG]),
        .vd        (vd_d)
    );

    // Result register and a flag marking that it holds a real result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vd_q  <= vd_d;
            vld_q <= 1'b1;
        end
    end

    // Output mapping
    always_comb begin
        perm_r    = vd_q.perm.r;
        perm_w    = vd_q.perm.w;
        perm_x    = vd_q.perm.x;
        grant     = vd_q.grant;
        flt_nxg   = vd_q.nxg;
        flt_prot  = vd_q.prot;
        flt_imask = vd_q.imsk;
        flt_dmask = vd_q.dmsk;
        flt_store = vd_q.store;
        rc_update = vd_q.rc_upd;
        ref_bit   = vd_q.ref_b;
        chg_bit   = vd_q.chg_b;
    end

    AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !(flt_nxg || flt_prot || flt_imask || flt_dmask || flt_store)); // R8
    AST_REF_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ref_bit); // R11
    AST_NONSTORE_NO_W: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && grant && $past(acc_type) != ACC_STORE) |-> !perm_w); // R11
    AST_NXG_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && $past(pte_lo[POS_NX] || pte_lo[POS_GRD])) |-> !perm_x); // R4
    AST_FETCH_CAUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_nxg && flt_prot)); // R9
    AST_DATA_NO_FETCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !$past(acc_type[1])) |-> !(flt_nxg || flt_imask)); // R10
    AST_MODE0_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && $past(key_mode) == 2'd0) |-> !(flt_imask || flt_dmask)); // R7
endmodule

// File: tb/tb_page_perm_eval.sv
module tb_page_perm_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        problem_state = 1'b0;
    logic        seg_kp = 1'b0;
    logic        seg_ks = 1'b0;
    logic [63:0] pte_lo = '0;
    logic [63:0] dmask = '0;
    logic [63:0] imask = '0;
    logic [1:0]  key_mode = '0;
    logic perm_r, perm_w, perm_x, grant, flt_nxg, flt_prot, flt_imask;
    logic flt_dmask, flt_store, rc_update, ref_bit, chg_bit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    page_perm_eval dut (
        .clk(clk), .rst_n(rst_n), .acc_type(acc_type),
        .problem_state(problem_state), .seg_kp(seg_kp), .seg_ks(seg_ks),
        .pte_lo(pte_lo), .dmask(dmask), .imask(imask), .key_mode(key_mode),
        .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x), .grant(grant),
        .flt_nxg(flt_nxg), .flt_prot(flt_prot), .flt_imask(flt_imask),
        .flt_dmask(flt_dmask), .flt_store(flt_store), .rc_update(rc_update),
        .ref_bit(ref_bit), .chg_bit(chg_bit)
    );

    // Expected {r,w,x,grant,nxg,prot,imask,dmask,store,rc_update,ref,chg}
    function automatic logic [11:0] model(input logic [1:0] a, input logic pr,
            input logic kp, input logic ks, input logic [63:0] p,
            input logic [63:0] dm, input logic [63:0] im, input logic [1:0] md);
        logic       key;
        logic [2:0] code, pp, nx, am, all, need;
        logic [4:0] pk;
        int         sh;
        logic       den, nxg, prf, imf, dmf, stf, rcu, rb, cb;
        key  = pr ? kp : ks;
        code = {p[63], p[1:0]};
        if (!key) pp = (code <= 3'd2) ? 3'b111 : ((code == 3'd3 || code == 3'd6) ? 3'b101 : 3'b000);
        else      pp = (code == 3'd2) ? 3'b111 : ((code == 3'd1 || code == 3'd3) ? 3'b101 : 3'b000);
        nx = (p[2] | p[3]) ? 3'b110 : 3'b111;
        pk = {p[61:60], p[11:9]};
        sh = 2 * (31 - int'(pk));
        am = 3'b111;
        if (md != 2'd0) begin
            if (dm[sh+1]) am[1] = 1'b0;
            if (dm[sh])   am[2] = 1'b0;
            if (md >= 2'd2 && im[sh]) am[0] = 1'b0;
        end
        all  = pp & nx & am;
        need = (a == 2'd0) ? 3'b100 : ((a == 2'd1) ? 3'b010 : 3'b001);
        den  = ((need & ~all) != 3'b000) || (a == 2'd3);
        {nxg, prf, imf, dmf, stf, rcu} = '0;
        rb = p[8];
        cb = p[7];
        if (den) begin
            if (a >= 2'd2) begin
                nxg = !nx[0];
                prf = nx[0] && !pp[0];
                imf = !am[0];
            end else begin
                prf = (need & ~pp) != 3'b000;
                dmf = (need & ~am) != 3'b000;
                stf = (a == 2'd1);
            end
        end else begin
            rb  = 1'b1;
            cb  = p[7] | (a == 2'd1);
            rcu = !p[8] || (a == 2'd1 && !p[7]);
            if (a != 2'd1) all[1] = 1'b0;
        end
        return {all, !den, nxg, prf, imf, dmf, stf, rcu, rb, cb};
    endfunction

    function automatic logic [11:0] outs();
        return {perm_r, perm_w, perm_x, grant, flt_nxg, flt_prot, flt_imask,
                flt_dmask, flt_store, rc_update, ref_bit, chg_bit};
    endfunction

    // Apply one vector at a falling edge and check it one rising edge later
    task automatic run(input logic [1:0] a, input logic pr, input logic kp,
            input logic ks, input logic [63:0] p, input logic [63:0] dm,
            input logic [63:0] im, input logic [1:0] md, input string tag);
        logic [11:0] exp;
        @(negedge clk);
        acc_type = a; problem_state = pr; seg_kp = kp; seg_ks = ks;
        pte_lo = p; dmask = dm; imask = im; key_mode = md;
        exp = model(a, pr, kp, ks, p, dm, im, md);
        @(negedge clk);
        checks++;
        if (outs() !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, outs(), exp);
        end
    endtask

    function automatic logic [63:0] mkpte(input logic [2:0] code, input logic [4:0] k,
            input logic n, input logic g, input logic r, input logic c);
        logic [63:0] p;
        p = '0;
        p[63] = code[2]; p[1:0] = code[1:0];
        p[61:60] = k[4:3]; p[11:9] = k[2:0];
        p[2] = n; p[3] = g; p[8] = r; p[7] = c;
        return p;
    endfunction

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        checks++;                               // R12 reset state
        if (outs() !== 12'd0) begin
            fails++;
            $display("FAIL R12: actual %b expected %b", outs(), 12'd0);
        end
        rst_n = 1'b1;
        // R1: problem state uses Kp; code 0 denied with key 1, allowed with key 0
        run(2'd0, 1'b1, 1'b1, 1'b0, mkpte(3'd0, 5'd0, 0, 0, 0, 0), '0, '0, 2'd0, "R1 kp");
        run(2'd0, 1'b0, 1'b1, 1'b0, mkpte(3'd0, 5'd0, 0, 0, 0, 0), '0, '0, 2'd0, "R1 ks");
        // R2: key 0 code 6 fetch granted, code 4 load denied
        run(2'd2, 1'b0, 1'b0, 1'b0, mkpte(3'd6, 5'd0, 0, 0, 1, 0), '0, '0, 2'd0, "R2 code6");
        run(2'd0, 1'b0, 1'b0, 1'b0, mkpte(3'd4, 5'd0, 0, 0, 1, 0), '0, '0, 2'd0, "R2 code4");
        // R3: key 1 code 2 store granted; code 3 store denied; code 6 load denied
        run(2'd1, 1'b0, 1'b0, 1'b1, mkpte(3'd2, 5'd0, 0, 0, 0, 0), '0, '0, 2'd0, "R3 code2");
        run(2'd1, 1'b0, 1'b0, 1'b1, mkpte(3'd3, 5'd0, 0, 0, 0, 0), '0, '0, 2'd0, "R3 code3");
        run(2'd0, 1'b0, 1'b0, 1'b1, mkpte(3'd6, 5'd0, 0, 0, 0, 0), '0, '0, 2'd0, "R3 code6");
        // R4: no-execute fetch denied, guarded load still granted
        run(2'd2, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd0, 1, 0, 0, 0), '0, '0, 2'd0, "R4 nx");
        run(2'd0, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd0, 0, 1, 0, 0), '0, '0, 2'd0, "R4 guard");
        // R5: key 5 store-forbid bit (bit 53), and a neighbour key's bit is ignored
        run(2'd1, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd5, 0, 0, 1, 1), 64'd1 << 53, '0, 2'd1, "R5 store");
        run(2'd1, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd5, 0, 0, 1, 1), 64'd1 << 51, '0, 2'd1, "R5 other key");
        run(2'd0, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd31, 0, 0, 1, 0), 64'd1, '0, 2'd1, "R5 load key31");
        // R6: instruction mask effective in mode 2, not in mode 1
        run(2'd2, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd9, 0, 0, 1, 0), '0, 64'd1 << 44, 2'd2, "R6 mode2");
        run(2'd2, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd9, 0, 0, 1, 0), '0, 64'd1 << 44, 2'd1, "R6 mode1");
        // R7: mode 0 ignores fully set masks
        run(2'd1, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd3, 0, 0, 0, 0), '1, '1, 2'd0, "R7 mode0");
        // R8: access type 3 always denied
        run(2'd3, 1'b0, 1'b0, 1'b0, mkpte(3'd0, 5'd0, 0, 0, 0, 0), '0, '0, 2'd0, "R8 type3");
        // R9: nx and table both refuse: only nx cause; plus instruction mask cause
        run(2'd2, 1'b0, 1'b0, 1'b1, mkpte(3'd0, 5'd0, 1, 0, 0, 0), '0, 64'd1 << 62, 2'd3, "R9 causes");
        run(2'd2, 1'b0, 1'b0, 1'b1, mkpte(3'd0, 5'd0, 0, 0, 0, 0), '0, '0, 2'd3, "R9 prot");
        // R10: store refused by table and data mask together
        run(2'd1, 1'b1, 1'b1, 1'b0, mkpte(3'd3, 5'd0, 0, 0, 0, 0), 64'd1 << 63, '0, 2'd1, "R10 store");
        // R11: granted load with referenced set needs no write-back; store sets changed
        run(2'd0, 1'b0, 1'b0, 1'b0, mkpte(3'd1, 5'd0, 0, 0, 1, 0), '0, '0, 2'd0, "R11 load");
        run(2'd1, 1'b0, 1'b0, 1'b0, mkpte(3'd1, 5'd0, 0, 0, 1, 0), '0, '0, 2'd0, "R11 store");
        // Random mix over all fields
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] p, dm, im;
            p  = {$urandom, $urandom};
            dm = {$urandom, $urandom} & {$urandom, $urandom};
            im = {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) p[3:2] = 2'b00;
            run(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
                p, dm, im, 2'($urandom_range(0, 3)), "R8 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule